// File: doc/BRIEF.md
# Masked Vector Lane Writeback Unit

This block is the final stage of a 512-bit vector operation. It takes the computed result vector and the previous contents of the destination. Under a per-element predicate it decides what is written back. The predicate comes from a small file of eight 64-bit mask registers, chosen by a 3-bit selector.

Enabled elements receive the result. Disabled elements either keep their old destination value or are cleared to zero, depending on a zeroing flag. The element size can be 32 or 64 bits. The written vector is registered and flagged valid one cycle after the operation is presented. The mask file has its own write port.

A separate combinational path prepares the second source operand. It either passes a memory vector through unchanged, or copies a single memory element into every lane.

Top module: `vec_masked_wb`

## Requirements
- R1: After reset, `wb_valid` is 0, `wb_data` is all zeros and every mask register holds zero.
- R2: `wb_valid` is high in exactly the cycle after a cycle with `op_valid` high, giving a latency of one cycle.
- R3: With `zero_en` = 0, a disabled element of `wb_data` equals the matching element of `old_dst`.
- R4: With `zero_en` = 1, a disabled element of `wb_data` is zero.
- R5: An enabled element of `wb_data` equals the matching element of `result`.
- R6: `esize` = 0 selects 16 elements of 32 bits, where element i occupies bits 32i+31..32i and is governed by mask bit i. `esize` = 1 selects 8 elements of 64 bits, where element i occupies bits 64i+63..64i and is governed by mask bit i. Mask bits above the element count have no effect.
- R7: `mask_sel` = 0 enables every element, whatever register 0 holds. Register 0 can still be written.
- R8: A write on the mask port changes the register at the next clock edge. An operation in the same cycle that selects the register being written uses its previous value.
- R9: With `bcast_en` = 1, every 32-bit lane of `src2_out` holds `mem_elem[31:0]` when `esize` = 0. Every 64-bit lane holds `mem_elem` when `esize` = 1. With `bcast_en` = 0, `src2_out` equals `mem_vec`.
- R10: In a cycle with `op_valid` low, `wb_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kwr_en | input | 1 | Mask register write strobe |
| kwr_idx | input | 3 | Mask register written |
| kwr_data | input | 64 | Mask register write value |
| op_valid | input | 1 | Operation presented this cycle |
| mask_sel | input | 3 | Mask register governing the operation (0 = unmasked) |
| zero_en | input | 1 | 1: clear disabled elements; 0: keep old values |
| esize | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| result | input | 512 | Computed result vector |
| old_dst | input | 512 | Previous destination contents |
| bcast_en | input | 1 | Replicate `mem_elem` into the second source |
| mem_elem | input | 64 | Single memory element |
| mem_vec | input | 512 | Full memory vector |
| src2_out | output | 512 | Prepared second source operand |
| wb_valid | output | 1 | Writeback vector valid |
| wb_data | output | 512 | Writeback vector |

## Verification
The merge and zero properties assume that `result` and `old_dst` are held steady while `op_valid` is high. The bench drives every input once per cycle on the falling edge, so this holds.

The properties also assume `esize` is a legal code. Because the port is a single bit, every value is legal.

The bench runs the full cross of selector, element size and zeroing flag over several data patterns. The mask contents in these patterns set the unused upper bits to nonzero values, so any effect those bits had would be visible.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
   typedef enum logic {
      ESZ_W32 = 1'b0,
      ESZ_W64 = 1'b1
   } esize_e;

   localparam int unsigned MIN_ELEM_W = 32;
   localparam int unsigned MAX_ELEM_W = 64;
endpackage

// File: rtl/vwb_mask_file.sv
module vwb_mask_file #(
   parameter int unsigned NUM_MASK = 8,
   parameter int unsigned MASK_W   = 64,
   parameter int unsigned RD_W     = 16,
   localparam int unsigned IDX_W   = $clog2(NUM_MASK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [MASK_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [RD_W-1:0]   rd_data
);
   generate
      if (RD_W > MASK_W) begin : g_bad_rd
         $error("vwb_mask_file: read width exceeds register width");
      end
   endgenerate

   logic [MASK_W-1:0] kreg [NUM_MASK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_MASK; i++) kreg[i] <= '0;
      end else if (wr_en) begin
         kreg[wr_idx] <= wr_data;
      end
   end

   // Read sees the stored value; a write in the same cycle lands afterwards.
   assign rd_data = kreg[rd_idx][RD_W-1:0];
endmodule

// File: rtl/vwb_lane_merge.sv
module vwb_lane_merge #(
   parameter int unsigned VLEN   = 512,
   parameter int unsigned LANE_W = 32,
   localparam int unsigned LANES = VLEN / LANE_W
) (
   input  logic [VLEN-1:0]  result,
   input  logic [VLEN-1:0]  old_dst,
   input  logic [LANES-1:0] mask,
   input  logic             unmasked,
   input  logic             zero_en,
   input  logic             wide,
   output logic [VLEN-1:0]  merged
);
   generate
      if ((LANES % 2) != 0) begin : g_bad_lanes
         $error("vwb_lane_merge: lane count must be even");
      end
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         logic en;
         assign en = unmasked | (wide ? mask[j/2] : mask[j]);
         always_comb begin
            if (en)           merged[j*LANE_W +: LANE_W] = result[j*LANE_W +: LANE_W];
            else if (zero_en) merged[j*LANE_W +: LANE_W] = '0;
            else              merged[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
         end
      end
   endgenerate
endmodule

// File: rtl/vwb_bcast.sv
module vwb_bcast #(
   parameter int unsigned VLEN   = 512,
   parameter int unsigned ELEM_W = 64,
   localparam int unsigned HALF_W = ELEM_W / 2,
   localparam int unsigned SLOTS  = VLEN / ELEM_W
) (
   input  logic              bcast_en,
   input  logic              wide,
   input  logic [ELEM_W-1:0] elem,
   input  logic [VLEN-1:0]   vec,
   output logic [VLEN-1:0]   src2
);
   logic [ELEM_W-1:0] rep;
   assign rep = wide ? elem : {2{elem[HALF_W-1:0]}};

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         assign src2[s*ELEM_W +: ELEM_W] = bcast_en ? rep : vec[s*ELEM_W +: ELEM_W];
      end
   endgenerate
endmodule

// File: rtl/vec_masked_wb.sv
module vec_masked_wb #(
   parameter int unsigned VLEN     = 512,
   parameter int unsigned NUM_MASK = 8,
   parameter int unsigned MASK_W   = 64,
   localparam int unsigned LANE_W  = vwb_pkg::MIN_ELEM_W,
   localparam int unsigned ELEM_W  = vwb_pkg::MAX_ELEM_W,
   localparam int unsigned LANES   = VLEN / LANE_W,
   localparam int unsigned IDX_W   = $clog2(NUM_MASK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kwr_en,
   input  logic [IDX_W-1:0]  kwr_idx,
   input  logic [MASK_W-1:0] kwr_data,
   input  logic              op_valid,
   input  logic [IDX_W-1:0]  mask_sel,
   input  logic              zero_en,
   input  logic              esize,
   input  logic [VLEN-1:0]   result,
   input  logic [VLEN-1:0]   old_dst,
   input  logic              bcast_en,
   input  logic [ELEM_W-1:0] mem_elem,
   input  logic [VLEN-1:0]   mem_vec,
   output logic [VLEN-1:0]   src2_out,
   output logic              wb_valid,
   output logic [VLEN-1:0]   wb_data
);
   import vwb_pkg::*;

   generate
      if ((VLEN % ELEM_W) != 0) begin : g_bad_vlen
         $error("vec_masked_wb: VLEN must be a multiple of the widest element");
      end
      if (LANES > MASK_W) begin : g_bad_mask
         $error("vec_masked_wb: mask register narrower than lane count");
      end
   endgenerate

   logic [LANES-1:0] mask_rd;
   logic [VLEN-1:0]  merged;
   logic             wide;

   assign wide = (esize_e'(esize) == ESZ_W64);

   vwb_mask_file #(
      .NUM_MASK(NUM_MASK), .MASK_W(MASK_W), .RD_W(LANES)
   ) u_kfile (
      .clk(clk), .rst_n(rst_n),
      .wr_en(kwr_en), .wr_idx(kwr_idx), .wr_data(kwr_data),
      .rd_idx(mask_sel), .rd_data(mask_rd)
   );

   vwb_lane_merge #(.VLEN(VLEN), .LANE_W(LANE_W)) u_merge (
      .result(result), .old_dst(old_dst), .mask(mask_rd),
      .unmasked(mask_sel == '0), .zero_en(zero_en), .wide(wide),
      .merged(merged)
   );

   vwb_bcast #(.VLEN(VLEN), .ELEM_W(ELEM_W)) u_bcast (
      .bcast_en(bcast_en), .wide(wide), .elem(mem_elem),
      .vec(mem_vec), .src2(src2_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_data  <= '0;
      end else begin
         wb_valid <= op_valid;
         if (op_valid) wb_data <= merged;
      end
   end
endmodule

// File: rtl/vwb_checker.sv
module vwb_checker #(
   parameter int unsigned VLEN   = 512,
   parameter int unsigned IDX_W  = 3,
   localparam int unsigned LANE_W = 32,
   localparam int unsigned LANES  = VLEN / LANE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [IDX_W-1:0] mask_sel,
   input logic             zero_en,
   input logic             esize,
   input logic [VLEN-1:0]  result,
   input logic [VLEN-1:0]  old_dst,
   input logic             bcast_en,
   input logic [63:0]      mem_elem,
   input logic [VLEN-1:0]  src2_out,
   input logic             wb_valid,
   input logic [VLEN-1:0]  wb_data
);
   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> wb_valid);
   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !wb_valid);
   // R10
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(wb_data));
   // R7
   unmasked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && mask_sel == '0) |=> wb_data == $past(result));

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
         // R4
         zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && zero_en) |=>
               (wb_data[j*LANE_W +: LANE_W] == '0 ||
                wb_data[j*LANE_W +: LANE_W] == $past(result[j*LANE_W +: LANE_W])));
         // R3
         merge_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && !zero_en) |=>
               (wb_data[j*LANE_W +: LANE_W] == $past(old_dst[j*LANE_W +: LANE_W]) ||
                wb_data[j*LANE_W +: LANE_W] == $past(result[j*LANE_W +: LANE_W])));
         // R9
         bcast_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bcast_en |-> src2_out[j*LANE_W +: LANE_W] ==
               ((esize && (j % 2 == 1)) ? mem_elem[63:32] : mem_elem[31:0]));
      end
   endgenerate
endmodule

bind vec_masked_wb vwb_checker #(.VLEN(VLEN), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .mask_sel(mask_sel),
   .zero_en(zero_en), .esize(esize), .result(result), .old_dst(old_dst),
   .bcast_en(bcast_en), .mem_elem(mem_elem), .src2_out(src2_out),
   .wb_valid(wb_valid), .wb_data(wb_data)
);

// File: tb/vec_masked_wb_test.sv
module vec_masked_wb_test;
   localparam int VLEN = 512;
   localparam int NL   = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            kwr_en = 1'b0;
   logic [2:0]      kwr_idx = '0;
   logic [63:0]     kwr_data = '0;
   logic            op_valid = 1'b0;
   logic [2:0]      mask_sel = '0;
   logic            zero_en = 1'b0;
   logic            esize = 1'b0;
   logic [VLEN-1:0] result = '0;
   logic [VLEN-1:0] old_dst = '0;
   logic            bcast_en = 1'b0;
   logic [63:0]     mem_elem = '0;
   logic [VLEN-1:0] mem_vec = '0;
   logic [VLEN-1:0] src2_out;
   logic            wb_valid;
   logic [VLEN-1:0] wb_data;

   int checks = 0;
   int failures = 0;
   logic [63:0] kmodel [8];

   always #10 clk = ~clk;

   vec_masked_wb uut (
      .clk(clk), .rst_n(rst_n), .kwr_en(kwr_en), .kwr_idx(kwr_idx),
      .kwr_data(kwr_data), .op_valid(op_valid), .mask_sel(mask_sel),
      .zero_en(zero_en), .esize(esize), .result(result), .old_dst(old_dst),
      .bcast_en(bcast_en), .mem_elem(mem_elem), .mem_vec(mem_vec),
      .src2_out(src2_out), .wb_valid(wb_valid), .wb_data(wb_data)
   );

   task automatic check(input string req, input logic [VLEN-1:0] act,
                        input logic [VLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [VLEN-1:0] expect_wb(input int sel, input logic z,
      input logic es, input logic [VLEN-1:0] res, input logic [VLEN-1:0] old,
      input logic [63:0] k);
      logic [VLEN-1:0] e;
      for (int j = 0; j < NL; j++) begin
         logic on;
         on = (sel == 0) ? 1'b1 : (es ? k[j/2] : k[j]);
         e[j*32 +: 32] = on ? res[j*32 +: 32] : (z ? 32'h0 : old[j*32 +: 32]);
      end
      return e;
   endfunction

   function automatic logic [VLEN-1:0] mk_vec(input int seed, input logic [31:0] top);
      logic [VLEN-1:0] v;
      for (int j = 0; j < NL; j++)
         v[j*32 +: 32] = top ^ (32'h0001_0203 * (seed + 1)) ^ (32'h0101 * j) ^ 32'h11;
      return v;
   endfunction

   task automatic write_mask(input int idx, input logic [63:0] d);
      @(negedge clk);
      kwr_en = 1'b1; kwr_idx = 3'(idx); kwr_data = d;
      @(negedge clk);
      kwr_en = 1'b0;
      kmodel[idx] = d;
   endtask

   task automatic run_op(input string req, input int sel, input logic z,
                         input logic es, input logic [VLEN-1:0] res,
                         input logic [VLEN-1:0] old);
      logic [VLEN-1:0] exp;
      exp = expect_wb(sel, z, es, res, old, kmodel[sel]);
      @(negedge clk);
      op_valid = 1'b1; mask_sel = 3'(sel); zero_en = z; esize = es;
      result = res; old_dst = old;
      @(negedge clk);
      op_valid = 1'b0;
      check("R2", {511'b0, wb_valid}, {511'b0, 1'b1});
      check(req, wb_data, exp);
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [VLEN-1:0] hold, rv, ov, ebc;
      for (int i = 0; i < 8; i++) kmodel[i] = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", {511'b0, wb_valid}, '0);
      check("R1", wb_data, '0);
      // R1: cleared masks -> every element disabled (merge)
      run_op("R1", 5, 1'b0, 1'b0, mk_vec(7, 32'hA000_0000), mk_vec(8, 32'h5000_0000));

      // load masks, upper bits nonzero (R6 ignore), k0 low bits zero (R7)
      begin
         logic [15:0] lo [8];
         lo[0] = 16'h0000; lo[1] = 16'h5555; lo[2] = 16'hAAAA; lo[3] = 16'h00FF;
         lo[4] = 16'hFF00; lo[5] = 16'h0001; lo[6] = 16'h8000; lo[7] = 16'hFFFF;
         for (int i = 0; i < 8; i++)
            write_mask(i, {48'hF0F0_1234_5678 ^ 48'(i), lo[i]});
      end

      // R3 R4 R5 R6 R7: sweep selector x size x zeroing x data
      for (int p = 0; p < 3; p++)
         for (int sel = 0; sel < 8; sel++)
            for (int es = 0; es < 2; es++)
               for (int z = 0; z < 2; z++) begin
                  rv = mk_vec(p, 32'h3C00_0000);
                  ov = mk_vec(p + 10, 32'hC300_0000);
                  run_op(z ? "R4/R5/R6/R7" : "R3/R5/R6/R7", sel, 1'(z), 1'(es), rv, ov);
               end

      // R10: idle cycle with changed inputs keeps output
      hold = wb_data;
      @(negedge clk);
      result = mk_vec(40, 32'h7777_0000); old_dst = mk_vec(41, 32'h8888_0000);
      @(negedge clk);
      check("R10", wb_data, hold);
      check("R2", {511'b0, wb_valid}, '0);

      // R8: same-cycle write and read of k3 uses the old value
      rv = mk_vec(50, 32'h1234_0000);
      ov = mk_vec(51, 32'h4321_0000);
      @(negedge clk);
      kwr_en = 1'b1; kwr_idx = 3'd3; kwr_data = 64'h0000_0000_0000_0F0F;
      op_valid = 1'b1; mask_sel = 3'd3; zero_en = 1'b1; esize = 1'b0;
      result = rv; old_dst = ov;
      @(negedge clk);
      kwr_en = 1'b0; op_valid = 1'b0;
      check("R8", wb_data, expect_wb(3, 1'b1, 1'b0, rv, ov, kmodel[3]));
      kmodel[3] = 64'h0000_0000_0000_0F0F;
      run_op("R8", 3, 1'b1, 1'b0, rv, ov);
      // R7: k0 is writable but still means unmasked
      write_mask(0, 64'h0);
      run_op("R7", 0, 1'b1, 1'b1, rv, ov);

      // R9: broadcast path
      @(negedge clk);
      mem_vec = mk_vec(60, 32'hBEEF_0000);
      mem_elem = 64'h0123_4567_89AB_CDEF;
      bcast_en = 1'b0; esize = 1'b0;
      #1 check("R9", src2_out, mem_vec);
      @(negedge clk);
      bcast_en = 1'b1; esize = 1'b0;
      for (int j = 0; j < NL; j++) ebc[j*32 +: 32] = 32'h89AB_CDEF;
      #1 check("R9", src2_out, ebc);
      @(negedge clk);
      esize = 1'b1;
      for (int j = 0; j < NL / 2; j++) ebc[j*64 +: 64] = 64'h0123_4567_89AB_CDEF;
      #1 check("R9", src2_out, ebc);
      @(negedge clk);
      bcast_en = 1'b0;

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule